// File: doc/BRIEF.md
# Disk Transfer Sequencer

This block runs one data-moving command of a cartridge disk controller: read, read without header check, write, or write-check. When a command starts, it checks the target against the drive state and turns the negative word count into a true length. It then clips that length so the transfer stops at the end of the current track and at the top of memory. After that it moves the data one 16-bit word at a time between a memory port and a disk-array port. Both ports use a request/acknowledge handshake.

When the data has moved, the block writes back the word count, the 22-bit byte address (a 6-bit extension plus a 16-bit bus address) and the disk address, each already advanced. It then raises `done_o` for one cycle. The register file around it latches the results and the error flags from the outputs. A command that fails its checks moves no data and leaves the result outputs equal to the command's inputs.

Top module: `xfer_seq`

## Requirements
- R1: Command encoding on `cmd_i` is 0 write-check, 1 write, 2 read, 3 read-without-header. The disk address holds the cylinder in bits 15:7, the track (cylinder and head) in bits 15:6 and the sector in bits 5:0. If the cylinder differs from `cur_cyl_i` (not checked for read-without-header), or the sector is 40 or more, the flags show summary, header error and incomplete. No port request is made and the results equal the inputs.
- R2: A command to a drive with `attached_i` low reports summary and incomplete and raises `rdy_drop_o`. It moves no data. This check takes priority over every other.
- R3: A write with `wlock_i` high raises `wgate_err_o` and reports summary and drive error. It moves no data. The lock has no effect on the other commands.
- R4: The true length is 65536 minus `count_i`, so a count of 0 means 65536. It is clipped to (40 - sector) x 128 words.
- R5: The word address is {ext, bus address} shifted right by one. If the word address plus the length exceeds `MEM_WORDS`, the non-existent-memory flag is set and the length is cut to `MEM_WORDS` minus the word address. If the word address itself exceeds `MEM_WORDS`, the command also reports incomplete, moves nothing and leaves the results unchanged. The block never requests a memory word at or above `MEM_WORDS`.
- R6: A read moves disk word (track x 40 + sector) x 128 + i to memory word address + i, for i from 0 to length - 1. Each port request is held, with a stable address, until it is acknowledged.
- R7: A write moves memory words to the same disk locations. If it ends partway through a 128-word sector, the rest of that sector is written with zero words.
- R8: A write-check reads both ports and writes to neither. Any mismatch sets summary and CRC error.
- R9: `count_o` is `count_i` plus the words moved, modulo 65536. A nonzero result sets summary and incomplete.
- R10: The byte address plus twice the words moved is split into `ext_o` (bits 21:16) and `ba_o` (bits 15:0). `da_o` is the disk address plus the number of sectors touched, rounded up.
- R11: `flags_o` bits are [5] summary (OR of the others), [4] drive error, [3] non-existent memory, [2] header error, [1] CRC error and [0] incomplete. `done_o` is a one-cycle pulse that comes only after all results are updated and no request is open. A `start_i` while `busy_o` is high is ignored.
- R12: After reset the block is idle: no requests, `done_o` and `busy_o` low, and all flags and results zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a command (ignored while busy) |
| cmd_i | input | 2 | Command code |
| da_i | input | 16 | Disk address (cylinder, head, sector) |
| ba_i | input | 16 | Bus byte address, low 16 bits |
| ext_i | input | 6 | Bus byte address, bits 21:16 |
| count_i | input | 16 | Negative two's-complement word count |
| cur_cyl_i | input | 9 | Drive's tracked cylinder |
| attached_i | input | 1 | Drive has media |
| wlock_i | input | 1 | Drive write-locked |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | 21 | Memory word address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data |
| mem_ack_i | input | 1 | Memory acknowledge |
| dsk_req_o | output | 1 | Disk-array request |
| dsk_we_o | output | 1 | Disk write (1) or read (0) |
| dsk_addr_o | output | 23 | Disk word address |
| dsk_wdata_o | output | 16 | Disk write data |
| dsk_rdata_i | input | 16 | Disk read data |
| dsk_ack_i | input | 1 | Disk acknowledge |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| flags_o | output | 6 | Error flags |
| count_o | output | 16 | Updated word count |
| ba_o | output | 16 | Updated bus address |
| ext_o | output | 6 | Updated address extension |
| da_o | output | 16 | Updated disk address |
| wgate_err_o | output | 1 | Set drive write-gate error |
| rdy_drop_o | output | 1 | Clear drive ready |

## Verification
A wrong length or base address in the sequencer shows up in the same command. The number of memory and disk acknowledges is off, the moved data lands at the wrong addresses, or the written-back count, addresses and incomplete flag disagree at `done_o`. A stuck word index or phase shows at once as a request that drops before its acknowledge, or as a command that never completes. Wrong padding shows as nonzero words at the tail of the last sector as soon as the write finishes. A lost mismatch flag shows at the end of the write-check that should have caught it.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [1:0] {
    CMD_WCHK = 2'd0,
    CMD_WR   = 2'd1,
    CMD_RD   = 2'd2,
    CMD_RDNH = 2'd3
  } cmd_e;

  // flag bit positions inside flags_o
  localparam int F_DRV = 4;
  localparam int F_NXM = 3;
  localparam int F_HDR = 2;
  localparam int F_CRC = 1;
  localparam int F_INC = 0;

  typedef enum logic [2:0] {
    T_IDLE, T_PLAN, T_XFER, T_WB, T_DONE
  } top_st_e;

  typedef enum logic [2:0] {
    E_IDLE, E_FIRST, E_SECOND, E_PAD, E_FIN
  } eng_st_e;
endpackage

// File: rtl/xfer_plan.sv
module xfer_plan
  import xfer_pkg::*;
#(
  parameter int SECTS      = 40,
  parameter int SECT_WORDS = 128,
  parameter int MEM_WORDS  = 1 << 20,
  parameter int NW_W       = 13,
  parameter int PA_W       = 21,
  parameter int SIDX_W     = 16
) (
  input  cmd_e              cmd_i,
  input  logic [15:0]       da_i,
  input  logic [15:0]       ba_i,
  input  logic [5:0]        ext_i,
  input  logic [15:0]       cnt_i,
  input  logic [8:0]        cur_cyl_i,
  output logic              hdr_bad_o,
  output logic              nxm_o,
  output logic              abort_o,
  output logic [NW_W-1:0]   n_words_o,
  output logic [PA_W-1:0]   pa_o,
  output logic [SIDX_W-1:0] sect_base_o
);
  logic [31:0] sect, true_wc, max_wc, wc, pa;

  always_comb begin
    sect      = {26'd0, da_i[5:0]};
    hdr_bad_o = ((cmd_i != CMD_RDNH) && (da_i[15:7] != cur_cyl_i)) ||
                (sect >= 32'(SECTS));
    true_wc   = 32'h0001_0000 - {16'd0, cnt_i};
    max_wc    = hdr_bad_o ? 32'd0 : (32'(SECTS) - sect) * 32'(SECT_WORDS);
    wc        = (true_wc > max_wc) ? max_wc : true_wc;
    pa        = {11'd0, ext_i, ba_i[15:1]};
    nxm_o     = (pa + wc) > 32'(MEM_WORDS);
    abort_o   = pa > 32'(MEM_WORDS);
    if (nxm_o) wc = abort_o ? 32'd0 : 32'(MEM_WORDS) - pa;
    n_words_o   = NW_W'(wc);
    pa_o        = PA_W'(pa);
    sect_base_o = SIDX_W'({22'd0, da_i[15:6]} * 32'(SECTS) + sect);
  end
endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
  import xfer_pkg::*;
#(
  parameter int SECT_WORDS = 128,
  parameter int NW_W       = 13,
  parameter int PA_W       = 21,
  parameter int SIDX_W     = 16,
  parameter int SW_LG      = 7,
  parameter int DSK_AW     = 23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  cmd_e              cmd_i,
  input  logic [NW_W-1:0]   n_words_i,
  input  logic [PA_W-1:0]   pa_i,
  input  logic [SIDX_W-1:0] sect_base_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [PA_W-1:0]   mem_addr_o,
  output logic [15:0]       mem_wdata_o,
  input  logic [15:0]       mem_rdata_i,
  input  logic              mem_ack_i,
  output logic              dsk_req_o,
  output logic              dsk_we_o,
  output logic [DSK_AW-1:0] dsk_addr_o,
  output logic [15:0]       dsk_wdata_o,
  input  logic [15:0]       dsk_rdata_i,
  input  logic              dsk_ack_i,
  output logic              mis_o,
  output logic              fin_o
);
  eng_st_e         st;
  logic [NW_W-1:0] idx, idx_nx;
  logic [15:0]     buf_q;
  logic            is_rd, first_ack, second_ack;

  assign is_rd      = cmd_i[1];
  assign idx_nx     = idx + NW_W'(1);
  assign first_ack  = is_rd ? dsk_ack_i : mem_ack_i;
  assign second_ack = is_rd ? mem_ack_i : dsk_ack_i;

  assign mem_req_o   = ((st == E_FIRST) && !is_rd) || ((st == E_SECOND) && is_rd);
  assign mem_we_o    = is_rd;
  assign mem_addr_o  = pa_i + PA_W'(idx);
  assign mem_wdata_o = buf_q;
  assign dsk_req_o   = ((st == E_FIRST) && is_rd) || ((st == E_SECOND) && !is_rd) ||
                       (st == E_PAD);
  assign dsk_we_o    = ((st == E_SECOND) && (cmd_i == CMD_WR)) || (st == E_PAD);
  assign dsk_addr_o  = {sect_base_i, SW_LG'(0)} + DSK_AW'(idx);
  assign dsk_wdata_o = (st == E_PAD) ? 16'd0 : buf_q;
  assign fin_o       = (st == E_FIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st    <= E_IDLE;
      idx   <= '0;
      buf_q <= '0;
      mis_o <= 1'b0;
    end else begin
      unique case (st)
        E_IDLE: if (go_i) begin
          idx   <= '0;
          mis_o <= 1'b0;
          st    <= (n_words_i == '0) ? E_FIN : E_FIRST;
        end
        E_FIRST: if (first_ack) begin
          buf_q <= is_rd ? dsk_rdata_i : mem_rdata_i;
          st    <= E_SECOND;
        end
        E_SECOND: if (second_ack) begin
          if ((cmd_i == CMD_WCHK) && (dsk_rdata_i != buf_q)) mis_o <= 1'b1;
          idx <= idx_nx;
          if (idx_nx == n_words_i)
            st <= ((cmd_i == CMD_WR) && (idx_nx[SW_LG-1:0] != '0)) ? E_PAD : E_FIN;
          else
            st <= E_FIRST;
        end
        E_PAD: if (dsk_ack_i) begin
          idx <= idx_nx;
          if (idx_nx[SW_LG-1:0] == '0) st <= E_FIN;
        end
        default: st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_pkg::*;
#(
  parameter int SECTS      = 40,
  parameter int SECT_WORDS = 128,
  parameter int MEM_WORDS  = 1 << 20
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [1:0]  cmd_i,
  input  logic [15:0] da_i,
  input  logic [15:0] ba_i,
  input  logic [5:0]  ext_i,
  input  logic [15:0] count_i,
  input  logic [8:0]  cur_cyl_i,
  input  logic        attached_i,
  input  logic        wlock_i,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [20:0] mem_addr_o,
  output logic [15:0] mem_wdata_o,
  input  logic [15:0] mem_rdata_i,
  input  logic        mem_ack_i,
  output logic        dsk_req_o,
  output logic        dsk_we_o,
  output logic [22:0] dsk_addr_o,
  output logic [15:0] dsk_wdata_o,
  input  logic [15:0] dsk_rdata_i,
  input  logic        dsk_ack_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [5:0]  flags_o,
  output logic [15:0] count_o,
  output logic [15:0] ba_o,
  output logic [5:0]  ext_o,
  output logic [15:0] da_o,
  output logic        wgate_err_o,
  output logic        rdy_drop_o
);
  localparam int PA_W   = 6 + 16 - 1;
  localparam int NW_W   = $clog2(SECTS * SECT_WORDS + 1);
  localparam int SW_LG  = $clog2(SECT_WORDS);
  localparam int SIDX_W = $clog2(1024 * SECTS);
  localparam int DSK_AW = SIDX_W + SW_LG;

  top_st_e     st;
  cmd_e        cmd_q;
  logic [15:0] da_q, ba_q, cnt_q;
  logic [5:0]  ext_q;
  logic [8:0]  cyl_q;
  logic        att_q, wl_q;
  logic [4:0]  fl_q;

  logic              hdr_bad, nxm, abort_cmd, go, mis, fin;
  logic [NW_W-1:0]   n_words;
  logic [PA_W-1:0]   pa;
  logic [SIDX_W-1:0] sect_base;
  logic [15:0]       new_cnt;
  logic [21:0]       end_byte;
  logic [31:0]       sect_adv;

  xfer_plan #(
    .SECTS(SECTS), .SECT_WORDS(SECT_WORDS), .MEM_WORDS(MEM_WORDS),
    .NW_W(NW_W), .PA_W(PA_W), .SIDX_W(SIDX_W)
  ) u_plan (
    .cmd_i(cmd_q), .da_i(da_q), .ba_i(ba_q), .ext_i(ext_q), .cnt_i(cnt_q),
    .cur_cyl_i(cyl_q), .hdr_bad_o(hdr_bad), .nxm_o(nxm), .abort_o(abort_cmd),
    .n_words_o(n_words), .pa_o(pa), .sect_base_o(sect_base)
  );

  assign go = (st == T_PLAN) && att_q && !((cmd_q == CMD_WR) && wl_q) &&
              !hdr_bad && !abort_cmd;

  xfer_engine #(
    .SECT_WORDS(SECT_WORDS), .NW_W(NW_W), .PA_W(PA_W), .SIDX_W(SIDX_W),
    .SW_LG(SW_LG), .DSK_AW(DSK_AW)
  ) u_eng (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(go), .cmd_i(cmd_q),
    .n_words_i(n_words), .pa_i(pa), .sect_base_i(sect_base),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i),
    .dsk_req_o(dsk_req_o), .dsk_we_o(dsk_we_o), .dsk_addr_o(dsk_addr_o),
    .dsk_wdata_o(dsk_wdata_o), .dsk_rdata_i(dsk_rdata_i), .dsk_ack_i(dsk_ack_i),
    .mis_o(mis), .fin_o(fin)
  );

  assign new_cnt  = cnt_q + 16'(n_words);
  assign end_byte = {pa + PA_W'(n_words), 1'b0};
  assign sect_adv = (32'(n_words) + 32'(SECT_WORDS - 1)) >> SW_LG;

  assign busy_o  = (st != T_IDLE);
  assign done_o  = (st == T_DONE);
  assign flags_o = {|fl_q, fl_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= T_IDLE;
      cmd_q <= CMD_WCHK;
      {da_q, ba_q, cnt_q, ext_q, cyl_q, att_q, wl_q} <= '0;
      fl_q <= '0;
      {count_o, ba_o, ext_o, da_o, wgate_err_o, rdy_drop_o} <= '0;
    end else begin
      unique case (st)
        T_IDLE: if (start_i) begin
          cmd_q <= cmd_e'(cmd_i);
          da_q  <= da_i;  ba_q  <= ba_i;  ext_q <= ext_i;  cnt_q <= count_i;
          cyl_q <= cur_cyl_i;  att_q <= attached_i;  wl_q <= wlock_i;
          count_o <= count_i;  ba_o <= ba_i;  ext_o <= ext_i;  da_o <= da_i;
          fl_q <= '0;  wgate_err_o <= 1'b0;  rdy_drop_o <= 1'b0;
          st <= T_PLAN;
        end
        T_PLAN: begin
          st <= T_DONE;
          if (!att_q) begin
            fl_q[F_INC] <= 1'b1;
            rdy_drop_o  <= 1'b1;
          end else if ((cmd_q == CMD_WR) && wl_q) begin
            fl_q[F_DRV] <= 1'b1;
            wgate_err_o <= 1'b1;
          end else if (hdr_bad) begin
            fl_q[F_HDR] <= 1'b1;
            fl_q[F_INC] <= 1'b1;
          end else if (abort_cmd) begin
            fl_q[F_NXM] <= 1'b1;
            fl_q[F_INC] <= 1'b1;
          end else begin
            fl_q[F_NXM] <= nxm;
            st <= T_XFER;
          end
        end
        T_XFER: if (fin) st <= T_WB;
        T_WB: begin
          count_o     <= new_cnt;
          fl_q[F_INC] <= (new_cnt != 16'd0);
          fl_q[F_CRC] <= mis;
          ext_o       <= end_byte[21:16];
          ba_o        <= end_byte[15:0];
          da_o        <= da_q + 16'(sect_adv);
          st          <= T_DONE;
        end
        default: st <= T_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk #(
  parameter int MEM_WORDS = 1 << 20
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mem_req_o,
  input logic        mem_ack_i,
  input logic [20:0] mem_addr_o,
  input logic        dsk_req_o,
  input logic        dsk_ack_i,
  input logic [22:0] dsk_addr_o,
  input logic        busy_o,
  input logic        done_o
);
  p_mem_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));

  p_dsk_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsk_req_o && !dsk_ack_i |=> dsk_req_o && $stable(dsk_addr_o));

  p_mem_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> ({11'd0, mem_addr_o} < 32'(MEM_WORDS)));

  p_done_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o && !mem_req_o && !dsk_req_o);

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !dsk_req_o);
endmodule

bind xfer_seq xfer_seq_chk #(.MEM_WORDS(MEM_WORDS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .mem_req_o(mem_req_o), .mem_ack_i(mem_ack_i), .mem_addr_o(mem_addr_o),
  .dsk_req_o(dsk_req_o), .dsk_ack_i(dsk_ack_i), .dsk_addr_o(dsk_addr_o),
  .busy_o(busy_o), .done_o(done_o)
);

// File: tb/sim_xfer_seq.sv
module sim_xfer_seq;
  localparam int CLK_PERIOD = 10;
  localparam int MEMW = 1 << 20;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  cmd = '0;
  logic [15:0] da = '0, ba = '0, cnt = '0;
  logic [5:0]  ext = '0;
  logic [8:0]  cyl = '0;
  logic        att = 1'b0, wl = 1'b0;
  logic        mem_req, mem_we, mem_ack, dsk_req, dsk_we, dsk_ack;
  logic [20:0] mem_addr;
  logic [22:0] dsk_addr;
  logic [15:0] mem_wdata, dsk_wdata;
  logic [15:0] mem_rdata = '0, dsk_rdata = '0;
  logic        busy, done, wge, rdy;
  logic [5:0]  flags, ext_o;
  logic [15:0] cnt_o, ba_o, da_o;
  logic [7:0]  lfsr = 8'h5B;
  int          n_mem = 0, n_dsk = 0, n_chk = 0, n_fail = 0;

  logic [15:0] memv [int];
  logic [15:0] dskv [int];

  typedef struct {
    logic [63:0] res;
    int nm, nd;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  xfer_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_i(cmd), .da_i(da),
    .ba_i(ba), .ext_i(ext), .count_i(cnt), .cur_cyl_i(cyl), .attached_i(att),
    .wlock_i(wl), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
    .dsk_req_o(dsk_req), .dsk_we_o(dsk_we), .dsk_addr_o(dsk_addr),
    .dsk_wdata_o(dsk_wdata), .dsk_rdata_i(dsk_rdata), .dsk_ack_i(dsk_ack),
    .busy_o(busy), .done_o(done), .flags_o(flags), .count_o(cnt_o), .ba_o(ba_o),
    .ext_o(ext_o), .da_o(da_o), .wgate_err_o(wge), .rdy_drop_o(rdy)
  );

  function automatic logic [15:0] mem_peek(int a);
    return memv.exists(a) ? memv[a] : (16'(a) ^ 16'h3C5A);
  endfunction
  function automatic logic [15:0] dsk_peek(int a);
    return dskv.exists(a) ? dskv[a] : (16'(a) ^ 16'hA5C3);
  endfunction

  // storage models with random stalls
  assign mem_ack = mem_req & lfsr[0];
  assign dsk_ack = dsk_req & lfsr[3];
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (mem_req && mem_ack && mem_we) memv[int'(mem_addr)] = mem_wdata;
    if (dsk_req && dsk_ack && dsk_we) dskv[int'(dsk_addr)] = dsk_wdata;
    if (start && !busy) begin
      n_mem <= 0;
      n_dsk <= 0;
    end else begin
      if (mem_req && mem_ack) n_mem <= n_mem + 1;
      if (dsk_req && dsk_ack) n_dsk <= n_dsk + 1;
    end
  end
  always @(negedge clk) begin
    mem_rdata <= mem_peek(int'(mem_addr));
    dsk_rdata <= dsk_peek(int'(dsk_addr));
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      logic [63:0] act;
      act = {2'b0, flags, cnt_o, ba_o, ext_o, da_o, wge, rdy};
      if (sb.size() == 0) begin
        chk(1'b0, "R11 unexpected done", act, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(act == e.res, e.tag, act, e.res);
        chk(n_mem == e.nm && n_dsk == e.nd, {e.tag, " access count"},
            64'({n_mem[31:0], n_dsk[31:0]}), 64'({e.nm[31:0], e.nd[31:0]}));
      end
    end
  end

  // expected results from the requirements
  task automatic model(input int c, input int d, input int b, input int x,
                       input int n, input int cy, input bit at, input bit lk,
                       input bit crc, input string tag);
    exp_t e;
    int fl, rc, rb, rx, rd, sect, wc, mx, pa, byt;
    bit g, r, nx;
    fl = 0; rc = n; rb = b; rx = x; rd = d; g = 0; r = 0;
    e.nm = 0; e.nd = 0; e.tag = tag;
    sect = d & 63;
    if (!at) begin fl = 6'b100001; r = 1; end
    else if (c == 1 && lk) begin fl = 6'b110000; g = 1; end
    else if ((c != 3 && (d >> 7) != cy) || sect >= 40) fl = 6'b100101;
    else begin
      wc = 65536 - n;
      mx = (40 - sect) * 128;
      if (wc > mx) wc = mx;
      pa = (x << 15) | (b >> 1);
      nx = 0;
      if (pa + wc > MEMW) begin nx = 1; wc = MEMW - pa; end
      if (wc < 0) fl = 6'b101001;
      else begin
        e.nm = wc;
        e.nd = (c == 1) ? ((wc + 127) / 128) * 128 : wc;
        rc = (n + wc) & 16'hFFFF;
        fl = {1'b0, 1'b0, nx, 1'b0, crc, (rc != 0)};
        if (fl != 0) fl |= 32;
        byt = (pa + wc) * 2;
        rx = (byt >> 16) & 63;
        rb = byt & 16'hFFFF;
        rd = (d + (wc + 127) / 128) & 16'hFFFF;
      end
    end
    e.res = {2'b0, 6'(fl), 16'(rc), 16'(rb), 6'(rx), 16'(rd), g, r};
    sb.push_back(e);
  endtask

  task automatic run(input int c, input int d, input int b, input int x,
                     input int n, input int cy, input bit at, input bit lk,
                     input bit crc, input string tag);
    model(c, d, b, x, n, cy, at, lk, crc, tag);
    @(negedge clk);
    cmd = 2'(c); da = 16'(d); ba = 16'(b); ext = 6'(x); cnt = 16'(n);
    cyl = 9'(cy); att = at; wl = lk; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait (sb.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!busy && !done && !mem_req && !dsk_req && flags == 0 && cnt_o == 0 &&
        ba_o == 0 && da_o == 0, "R12 reset", 64'({busy, done, mem_req, dsk_req, flags}), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4 R6 R9 R10: read clipped at track end (cyl 5 head 1 sector 38)
    run(2, 742, 16'h1000, 0, 65536 - 300, 5, 1, 0, 0, "R4 R9 R10 clip read");
    chk(mem_peek(16'h800) == dsk_peek(478 * 128), "R6 first word",
        64'(mem_peek(16'h800)), 64'(dsk_peek(478 * 128)));
    chk(mem_peek(16'h800 + 255) == dsk_peek(478 * 128 + 255), "R6 last word",
        64'(mem_peek(16'h8FF)), 64'(dsk_peek(478 * 128 + 255)));
    // R9 exact count, R10 with extension
    run(2, 640, 16'h2000, 2, 65536 - 128, 5, 1, 0, 0, "R9 R10 exact read");
    // R4 count zero means 65536
    run(2, 640 | 39, 0, 0, 0, 5, 1, 0, 0, "R4 zero count");
    // R1 header mismatch and sector range
    run(2, 768, 0, 0, 65536 - 10, 5, 1, 0, 0, "R1 cylinder mismatch");
    run(3, 768, 16'h3000, 0, 65536 - 10, 5, 1, 0, 0, "R1 no-header skips cylinder");
    run(3, 640 | 40, 0, 0, 65536 - 10, 5, 1, 0, 0, "R1 sector 40");
    // R2 unattached, priority over lock
    run(1, 640, 0, 0, 65536 - 10, 5, 0, 1, 0, "R2 unattached");
    // R3 locked write and lock ignored on read
    run(1, 640, 0, 0, 65536 - 10, 5, 1, 1, 0, "R3 locked write");
    run(2, 640, 16'h5000, 0, 65536 - 4, 5, 1, 1, 0, "R3 lock ignored on read");
    // R7 write with padding (sector 3)
    run(1, 643, 16'h4000, 0, 65536 - 130, 5, 1, 0, 0, "R7 write");
    chk(dskv[403 * 128] == mem_peek(16'h2000), "R7 data word",
        64'(dskv[403 * 128]), 64'(mem_peek(16'h2000)));
    chk(dskv.exists(403 * 128 + 255) && dskv[403 * 128 + 255] == 0 &&
        dskv[403 * 128 + 130] == 0, "R7 pad zero",
        64'(dskv[403 * 128 + 255]), 64'd0);
    // R8 write-check match and mismatch
    run(0, 643, 16'h4000, 0, 65536 - 130, 5, 1, 0, 0, "R8 check match");
    memv[16'h2005] = ~mem_peek(16'h2005);
    run(0, 643, 16'h4000, 0, 65536 - 130, 5, 1, 0, 1, "R8 check mismatch");
    // R5 memory top clip and abort
    run(2, 640, 16'hFF00, 6'h1F, 65536 - 256, 5, 1, 0, 0, "R5 nxm clip");
    run(2, 640, 0, 6'h21, 65536 - 16, 5, 1, 0, 0, "R5 nxm abort");
    // R11 start while busy ignored
    model(2, 640, 16'h6000, 0, 65536 - 64, 5, 1, 0, 0, "R11 busy start ignored");
    @(negedge clk);
    cmd = 2'd2; da = 16'd640; ba = 16'h6000; ext = 0; cnt = 16'(65536 - 64);
    cyl = 9'd5; att = 1; wl = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    cmd = 2'd1; cnt = 16'hFFFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait (sb.size() == 0);
    repeat (20) @(negedge clk);
    chk(!busy, "R11 single completion", 64'(busy), 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule